// File: doc/BRIEF.md
# Register Transfer and Exchange Unit

This block works out the register writes for the register-to-register operations of a small 16-bit processor core. The supported operations are generic copy, swap, sign-widen and two dedicated accumulator copies that also set flags. The operands are two 8-bit accumulators (A, B), their 16-bit pair D, and three 16-bit registers (X, Y, SP). The core's register file feeds the current values into the block. The block returns per-register write enables and write data, plus an optional update of the N, Z and V flags. It stores no register contents itself.

Each request is sampled on a rising clock edge. Its write and flag outputs appear on the registered outputs after that same edge and stay there for one cycle. The pair D is treated as A in the high byte and B in the low byte. A write to D therefore drives both accumulator ports. Moves between 8-bit and 16-bit registers follow fixed widening and narrowing rules.

Top module: `regx_xfer_unit`

## Requirements
- R1: Synchronous active-high reset clears all write enables, write data and flag outputs. A request sampled on a rising edge shows on the outputs right after that edge. Any data output whose enable is low is zero, and the flag outputs are zero when flag_upd is low.
- R2: When op_valid is low, or op_code is 5, 6 or 7, no write enable and no flag_upd is raised.
- R3: op_code 0 (generic copy) writes the register named by dst_sel with the value of src_sel and never raises flag_upd. Select codes are 0=A, 1=B, 2=D, 3=X, 4=Y, 5=SP.
- R4: A copy from an 8-bit accumulator into a 16-bit register clears the upper byte. A copy from a 16-bit register into an accumulator keeps only bits 7..0.
- R5: D reads as {A,B}. A write to D raises both accumulator enables, with the high byte on A and the low byte on B.
- R6: op_code 1 (swap) writes both registers from their values before the operation. The accumulator receives the low byte of a 16-bit partner, and the 16-bit partner receives the accumulator zero-extended.
- R7: A swap whose src_sel equals dst_sel raises no write enable.
- R8: In a swap between D and A or B, the write aimed directly at the accumulator takes precedence over the D write on the overlapping byte. So D<->A exchanges A and B, and D<->B writes A=0 and B unchanged.
- R9: op_code 2 (sign-widen) takes the low byte of src_sel and copies its bit 7 into bits 15..8 for a 16-bit dst_sel. An accumulator dst_sel receives the byte only. flag_upd stays low.
- R10: op_code 3 copies A into B and op_code 4 copies B into A, ignoring both selects. Each raises flag_upd with N = bit 7 of the moved byte, Z = 1 when the byte is zero, and V = 0.
- R11: Select codes 6 and 7 read as zero when used as a source and cause no write when used as a destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request present this cycle |
| op_code | input | 3 | Operation: 0 copy, 1 swap, 2 sign-widen, 3 A to B, 4 B to A |
| src_sel | input | 3 | Source register select |
| dst_sel | input | 3 | Destination register select |
| cur_a | input | 8 | Current A |
| cur_b | input | 8 | Current B |
| cur_x | input | 16 | Current X |
| cur_y | input | 16 | Current Y |
| cur_s | input | 16 | Current SP |
| wr_a_en | output | 1 | Write A |
| wr_a_data | output | 8 | New A |
| wr_b_en | output | 1 | Write B |
| wr_b_data | output | 8 | New B |
| wr_x_en | output | 1 | Write X |
| wr_x_data | output | 16 | New X |
| wr_y_en | output | 1 | Write Y |
| wr_y_data | output | 16 | New Y |
| wr_s_en | output | 1 | Write SP |
| wr_s_data | output | 16 | New SP |
| flag_upd | output | 1 | Update N, Z, V |
| flag_n | output | 1 | New N |
| flag_z | output | 1 | New Z |
| flag_v | output | 1 | New V |

## Verification
The bench targets width mismatches. A design that forgets to clear the upper byte leaks stale bits into X or Y, and one that narrows from the wrong byte hands the high half to an accumulator. Swaps that involve D against one of its own halves expose any priority mistake as a wrong A or B value. Self-swaps expose stray enables. A sign-widen of 0x80 and of 0x7F separates sign fill from zero fill. A zero byte moved by a dedicated copy catches a wrong Z, and a generic copy catches a design that raises flags it must not.

// File: rtl/regx_pkg.sv
package regx_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int SEL_W  = 3;
    localparam int OPC_W  = 3;
    localparam int NPORT  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_A  = 3'd0,
        SEL_B  = 3'd1,
        SEL_D  = 3'd2,
        SEL_X  = 3'd3,
        SEL_Y  = 3'd4,
        SEL_SP = 3'd5,
        SEL_N6 = 3'd6,
        SEL_N7 = 3'd7
    } rsel_e;

    typedef enum logic [OPC_W-1:0] {
        OPC_COPY = 3'd0,
        OPC_SWAP = 3'd1,
        OPC_SEXT = 3'd2,
        OPC_A2B  = 3'd3,
        OPC_B2A  = 3'd4,
        OPC_RS5  = 3'd5,
        OPC_RS6  = 3'd6,
        OPC_RS7  = 3'd7
    } opc_e;

    typedef struct packed {
        logic              a_en;
        logic [BYTE_W-1:0] a_d;
        logic              b_en;
        logic [BYTE_W-1:0] b_d;
        logic              x_en;
        logic [WORD_W-1:0] x_d;
        logic              y_en;
        logic [WORD_W-1:0] y_d;
        logic              s_en;
        logic [WORD_W-1:0] s_d;
    } wr_set_t;

    function automatic logic is_narrow(rsel_e s);
        return (s == SEL_A) || (s == SEL_B);
    endfunction

    // Shape a source value for a destination of the given width class.
    function automatic logic [WORD_W-1:0] fit_to(logic [WORD_W-1:0] v, rsel_e dst);
        return is_narrow(dst) ? {{BYTE_W{1'b0}}, v[BYTE_W-1:0]} : v;
    endfunction

    function automatic logic [WORD_W-1:0] sign_widen(logic [BYTE_W-1:0] v);
        return {{BYTE_W{v[BYTE_W-1]}}, v};
    endfunction

endpackage

// File: rtl/regx_operand_mux.sv
module regx_operand_mux
    import regx_pkg::*;
(
    input  rsel_e             sel,
    input  logic [BYTE_W-1:0] cur_a,
    input  logic [BYTE_W-1:0] cur_b,
    input  logic [WORD_W-1:0] cur_x,
    input  logic [WORD_W-1:0] cur_y,
    input  logic [WORD_W-1:0] cur_s,
    output logic [WORD_W-1:0] val
);
    always_comb begin
        unique case (sel)
            SEL_A:   val = {{BYTE_W{1'b0}}, cur_a};
            SEL_B:   val = {{BYTE_W{1'b0}}, cur_b};
            SEL_D:   val = {cur_a, cur_b};
            SEL_X:   val = cur_x;
            SEL_Y:   val = cur_y;
            SEL_SP:  val = cur_s;
            default: val = '0;
        endcase
    end
endmodule

// File: rtl/regx_write_route.sv
module regx_write_route
    import regx_pkg::*;
(
    input  logic              en,
    input  rsel_e             sel,
    input  logic [WORD_W-1:0] data,
    output wr_set_t           req
);
    always_comb begin
        req = '0;
        if (en) begin
            unique case (sel)
                SEL_A: begin
                    req.a_en = 1'b1;
                    req.a_d  = data[BYTE_W-1:0];
                end
                SEL_B: begin
                    req.b_en = 1'b1;
                    req.b_d  = data[BYTE_W-1:0];
                end
                SEL_D: begin
                    req.a_en = 1'b1;
                    req.a_d  = data[WORD_W-1:BYTE_W];
                    req.b_en = 1'b1;
                    req.b_d  = data[BYTE_W-1:0];
                end
                SEL_X: begin
                    req.x_en = 1'b1;
                    req.x_d  = data;
                end
                SEL_Y: begin
                    req.y_en = 1'b1;
                    req.y_d  = data;
                end
                SEL_SP: begin
                    req.s_en = 1'b1;
                    req.s_d  = data;
                end
                default: req = '0;
            endcase
        end
    end
endmodule

// File: rtl/regx_xfer_unit.sv
module regx_xfer_unit
    import regx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [OPC_W-1:0]    op_code,
    input  logic [SEL_W-1:0]    src_sel,
    input  logic [SEL_W-1:0]    dst_sel,
    input  logic [BYTE_W-1:0]   cur_a,
    input  logic [BYTE_W-1:0]   cur_b,
    input  logic [WORD_W-1:0]   cur_x,
    input  logic [WORD_W-1:0]   cur_y,
    input  logic [WORD_W-1:0]   cur_s,
    output logic                wr_a_en,
    output logic [BYTE_W-1:0]   wr_a_data,
    output logic                wr_b_en,
    output logic [BYTE_W-1:0]   wr_b_data,
    output logic                wr_x_en,
    output logic [WORD_W-1:0]   wr_x_data,
    output logic                wr_y_en,
    output logic [WORD_W-1:0]   wr_y_data,
    output logic                wr_s_en,
    output logic [WORD_W-1:0]   wr_s_data,
    output logic                flag_upd,
    output logic                flag_n,
    output logic                flag_z,
    output logic                flag_v
);
    opc_e  opc;
    rsel_e src_e;
    rsel_e dst_e;
    assign opc   = opc_e'(op_code);
    assign src_e = rsel_e'(src_sel);
    assign dst_e = rsel_e'(dst_sel);

    // Port 0 reads the source and writes the destination; port 1 the reverse.
    rsel_e             rd_sel  [NPORT];
    logic [WORD_W-1:0] rd_val  [NPORT];
    rsel_e             wr_sel  [NPORT];
    logic              wr_en   [NPORT];
    logic [WORD_W-1:0] wr_val  [NPORT];
    wr_set_t           wr_req  [NPORT];

    assign rd_sel[0] = src_e;
    assign rd_sel[1] = dst_e;

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        regx_operand_mux u_mux (
            .sel   (rd_sel[i]),
            .cur_a (cur_a),
            .cur_b (cur_b),
            .cur_x (cur_x),
            .cur_y (cur_y),
            .cur_s (cur_s),
            .val   (rd_val[i])
        );
        regx_write_route u_route (
            .en   (wr_en[i]),
            .sel  (wr_sel[i]),
            .data (wr_val[i]),
            .req  (wr_req[i])
        );
    end

    logic              fl_en;
    logic [BYTE_W-1:0] fl_byte;

    always_comb begin
        wr_en[0]  = 1'b0;
        wr_en[1]  = 1'b0;
        wr_sel[0] = dst_e;
        wr_sel[1] = src_e;
        wr_val[0] = '0;
        wr_val[1] = '0;
        fl_en     = 1'b0;
        fl_byte   = '0;
        if (op_valid) begin
            unique case (opc)
                OPC_COPY: begin
                    wr_en[0]  = 1'b1;
                    wr_val[0] = fit_to(rd_val[0], dst_e);
                end
                OPC_SWAP: begin
                    if (src_e != dst_e) begin
                        wr_en[0]  = 1'b1;
                        wr_val[0] = fit_to(rd_val[0], dst_e);
                        wr_en[1]  = 1'b1;
                        wr_val[1] = fit_to(rd_val[1], src_e);
                    end
                end
                OPC_SEXT: begin
                    wr_en[0]  = 1'b1;
                    wr_val[0] = fit_to(sign_widen(rd_val[0][BYTE_W-1:0]), dst_e);
                end
                OPC_A2B: begin
                    wr_en[0]  = 1'b1;
                    wr_sel[0] = SEL_B;
                    wr_val[0] = {{BYTE_W{1'b0}}, cur_a};
                    fl_en     = 1'b1;
                    fl_byte   = cur_a;
                end
                OPC_B2A: begin
                    wr_en[0]  = 1'b1;
                    wr_sel[0] = SEL_A;
                    wr_val[0] = {{BYTE_W{1'b0}}, cur_b};
                    fl_en     = 1'b1;
                    fl_byte   = cur_b;
                end
                default: ;
            endcase
        end
    end

    // Merge both ports; a write naming an accumulator directly beats one via D.
    wr_set_t merged;
    always_comb begin
        merged = '0;
        if (wr_req[1].a_en && is_narrow(wr_sel[1])) begin
            merged.a_en = 1'b1; merged.a_d = wr_req[1].a_d;
        end else if (wr_req[0].a_en) begin
            merged.a_en = 1'b1; merged.a_d = wr_req[0].a_d;
        end else if (wr_req[1].a_en) begin
            merged.a_en = 1'b1; merged.a_d = wr_req[1].a_d;
        end
        if (wr_req[1].b_en && is_narrow(wr_sel[1])) begin
            merged.b_en = 1'b1; merged.b_d = wr_req[1].b_d;
        end else if (wr_req[0].b_en) begin
            merged.b_en = 1'b1; merged.b_d = wr_req[0].b_d;
        end else if (wr_req[1].b_en) begin
            merged.b_en = 1'b1; merged.b_d = wr_req[1].b_d;
        end
        merged.x_en = wr_req[0].x_en | wr_req[1].x_en;
        merged.x_d  = wr_req[0].x_d  | wr_req[1].x_d;
        merged.y_en = wr_req[0].y_en | wr_req[1].y_en;
        merged.y_d  = wr_req[0].y_d  | wr_req[1].y_d;
        merged.s_en = wr_req[0].s_en | wr_req[1].s_en;
        merged.s_d  = wr_req[0].s_d  | wr_req[1].s_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            {wr_a_en, wr_a_data, wr_b_en, wr_b_data} <= '0;
            {wr_x_en, wr_x_data, wr_y_en, wr_y_data} <= '0;
            {wr_s_en, wr_s_data}                     <= '0;
            {flag_upd, flag_n, flag_z, flag_v}       <= '0;
        end else begin
            wr_a_en   <= merged.a_en;
            wr_a_data <= merged.a_d;
            wr_b_en   <= merged.b_en;
            wr_b_data <= merged.b_d;
            wr_x_en   <= merged.x_en;
            wr_x_data <= merged.x_d;
            wr_y_en   <= merged.y_en;
            wr_y_data <= merged.y_d;
            wr_s_en   <= merged.s_en;
            wr_s_data <= merged.s_d;
            flag_upd  <= fl_en;
            flag_n    <= fl_en & fl_byte[BYTE_W-1];
            flag_z    <= fl_en & (fl_byte == '0);
            flag_v    <= 1'b0;
        end
    end

    // R2: idle or reserved requests leave every output enable low
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!op_valid || op_code > 3'd4) |=>
        !(wr_a_en || wr_b_en || wr_x_en || wr_y_en || wr_s_en || flag_upd));

    // R3: a generic copy never touches the flags
    a_r3_copy_no_flags: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd0) |=> !flag_upd);

    // R4: accumulator widened into Y has a zero upper byte
    a_r4_widen_zero: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd0 && src_sel <= 3'd1 && dst_sel == 3'd4)
        |=> (wr_y_en && wr_y_data[WORD_W-1:BYTE_W] == '0));

    // R7: self swap writes nothing
    a_r7_self_swap: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd1 && src_sel == dst_sel) |=>
        !(wr_a_en || wr_b_en || wr_x_en || wr_y_en || wr_s_en));

    // R9: sign-widen into X replicates bit 7
    a_r9_sext_fill: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd2 && dst_sel == 3'd3) |=>
        (wr_x_en && wr_x_data[WORD_W-1:BYTE_W] == {BYTE_W{wr_x_data[BYTE_W-1]}}));

    // R10: A-to-B flags follow the moved byte
    a_r10_a2b_flags: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd3) |=>
        (flag_upd && wr_b_en && !flag_v && flag_n == wr_b_data[BYTE_W-1]
         && flag_z == (wr_b_data == '0)));

endmodule

// File: tb/sim_regx_xfer_unit.sv
module sim_regx_xfer_unit;
    logic clk = 1'b0;
    logic rst;
    logic op_valid;
    logic [2:0] op_code, src_sel, dst_sel;
    logic [7:0] cur_a, cur_b;
    logic [15:0] cur_x, cur_y, cur_s;
    logic wr_a_en, wr_b_en, wr_x_en, wr_y_en, wr_s_en;
    logic [7:0] wr_a_data, wr_b_data;
    logic [15:0] wr_x_data, wr_y_data, wr_s_data;
    logic flag_upd, flag_n, flag_z, flag_v;

    always #2 clk = ~clk;   // 250 MHz

    regx_xfer_unit u0 (.*);

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // Expected outputs
    logic ea, eb, ex, ey, es, ef, en_, ez, ev;
    logic [7:0] da, db;
    logic [15:0] dx, dy, ds;

    function automatic logic [15:0] rd(input logic [2:0] s);
        case (s)
            3'd0: return {8'h00, cur_a};
            3'd1: return {8'h00, cur_b};
            3'd2: return {cur_a, cur_b};
            3'd3: return cur_x;
            3'd4: return cur_y;
            3'd5: return cur_s;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] fitv(input logic [15:0] v, input logic [2:0] s);
        return (s <= 3'd1) ? {8'h00, v[7:0]} : v;
    endfunction

    task automatic put(input logic [2:0] s, input logic [15:0] v);
        case (s)
            3'd0: begin ea = 1; da = v[7:0]; end
            3'd1: begin eb = 1; db = v[7:0]; end
            3'd2: begin ea = 1; da = v[15:8]; eb = 1; db = v[7:0]; end
            3'd3: begin ex = 1; dx = v; end
            3'd4: begin ey = 1; dy = v; end
            3'd5: begin es = 1; ds = v; end
            default: ;
        endcase
    endtask

    task automatic model();
        logic [15:0] vs, vd;
        logic [7:0] bt;
        {ea, eb, ex, ey, es, ef, en_, ez, ev} = '0;
        da = 0; db = 0; dx = 0; dy = 0; ds = 0;
        if (op_valid) begin
            case (op_code)
                3'd0: put(dst_sel, fitv(rd(src_sel), dst_sel));
                3'd1: if (src_sel != dst_sel) begin
                    vs = rd(src_sel); vd = rd(dst_sel);
                    // the accumulator-side write is applied last so it wins
                    if (dst_sel <= 3'd1) begin
                        put(src_sel, fitv(vd, src_sel));
                        put(dst_sel, fitv(vs, dst_sel));
                    end else begin
                        put(dst_sel, fitv(vs, dst_sel));
                        put(src_sel, fitv(vd, src_sel));
                    end
                end
                3'd2: begin
                    bt = rd(src_sel) & 16'h00FF;
                    put(dst_sel, (dst_sel <= 3'd1) ? {8'h00, bt} : {{8{bt[7]}}, bt});
                end
                3'd3, 3'd4: begin
                    bt = (op_code == 3'd3) ? cur_a : cur_b;
                    put((op_code == 3'd3) ? 3'd1 : 3'd0, {8'h00, bt});
                    ef = 1; en_ = bt[7]; ez = (bt == 0); ev = 0;
                end
                default: ;
            endcase
        end
    endtask

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "a_en", 16'(wr_a_en), 16'(ea)); chk(tag, "a_data", 16'(wr_a_data), 16'(da));
        chk(tag, "b_en", 16'(wr_b_en), 16'(eb)); chk(tag, "b_data", 16'(wr_b_data), 16'(db));
        chk(tag, "x_en", 16'(wr_x_en), 16'(ex)); chk(tag, "x_data", wr_x_data, dx);
        chk(tag, "y_en", 16'(wr_y_en), 16'(ey)); chk(tag, "y_data", wr_y_data, dy);
        chk(tag, "s_en", 16'(wr_s_en), 16'(es)); chk(tag, "s_data", wr_s_data, ds);
        chk(tag, "flag_upd", 16'(flag_upd), 16'(ef)); chk(tag, "flag_n", 16'(flag_n), 16'(en_));
        chk(tag, "flag_z", 16'(flag_z), 16'(ez)); chk(tag, "flag_v", 16'(flag_v), 16'(ev));
    endtask

    task automatic step(input string tag, input logic v, input logic [2:0] op,
                        input logic [2:0] s, input logic [2:0] d,
                        input logic [7:0] a, input logic [7:0] b,
                        input logic [15:0] x, input logic [15:0] y, input logic [15:0] sp);
        @(negedge clk);
        op_valid = v; op_code = op; src_sel = s; dst_sel = d;
        cur_a = a; cur_b = b; cur_x = x; cur_y = y; cur_s = sp;
        model();
        @(posedge clk);
        #1;
        compare(tag);
    endtask

    initial begin
        rst = 1; op_valid = 0; op_code = 0; src_sel = 0; dst_sel = 0;
        cur_a = 8'hA5; cur_b = 8'h3C; cur_x = 16'h1234; cur_y = 16'h5678; cur_s = 16'h9ABC;
        repeat (3) @(posedge clk);
        #1;
        {ea, eb, ex, ey, es, ef, en_, ez, ev} = '0;
        da = 0; db = 0; dx = 0; dy = 0; ds = 0;
        compare("R1_reset");
        @(negedge clk); rst = 0;

        step("R2_invalid", 0, 3'd0, 3'd3, 3'd4, 8'h11, 8'h22, 16'hAAAA, 16'hBBBB, 16'hCCCC);
        step("R2_reserved", 1, 3'd6, 3'd3, 3'd4, 8'h11, 8'h22, 16'hAAAA, 16'hBBBB, 16'hCCCC);
        step("R3_x_to_y", 1, 3'd0, 3'd3, 3'd4, 8'h11, 8'h22, 16'hAAAA, 16'hBBBB, 16'hCCCC);
        step("R3_a_to_b", 1, 3'd0, 3'd0, 3'd1, 8'h00, 8'h22, 16'hAAAA, 16'hBBBB, 16'hCCCC);
        step("R4_a_to_x", 1, 3'd0, 3'd0, 3'd3, 8'h9C, 8'h22, 16'hFFFF, 16'hBBBB, 16'hCCCC);
        step("R4_sp_to_b", 1, 3'd0, 3'd5, 3'd1, 8'h11, 8'h22, 16'hAAAA, 16'hBBBB, 16'hC3D4);
        step("R5_x_to_d", 1, 3'd0, 3'd3, 3'd2, 8'h11, 8'h22, 16'hBEEF, 16'hBBBB, 16'hCCCC);
        step("R5_d_to_y", 1, 3'd0, 3'd2, 3'd4, 8'h12, 8'h34, 16'hAAAA, 16'hBBBB, 16'hCCCC);
        step("R6_swap_a_x", 1, 3'd1, 3'd0, 3'd3, 8'h5A, 8'h22, 16'hF00D, 16'hBBBB, 16'hCCCC);
        step("R6_swap_x_y", 1, 3'd1, 3'd3, 3'd4, 8'h11, 8'h22, 16'h1111, 16'h2222, 16'hCCCC);
        step("R7_self_x", 1, 3'd1, 3'd3, 3'd3, 8'h11, 8'h22, 16'h1111, 16'h2222, 16'hCCCC);
        step("R7_self_d", 1, 3'd1, 3'd2, 3'd2, 8'h11, 8'h22, 16'h1111, 16'h2222, 16'hCCCC);
        step("R8_swap_d_a", 1, 3'd1, 3'd2, 3'd0, 8'h7E, 8'h81, 16'h1111, 16'h2222, 16'hCCCC);
        step("R8_swap_b_d", 1, 3'd1, 3'd1, 3'd2, 8'h7E, 8'h81, 16'h1111, 16'h2222, 16'hCCCC);
        step("R9_sext_neg", 1, 3'd2, 3'd0, 3'd3, 8'h80, 8'h22, 16'h0000, 16'h2222, 16'hCCCC);
        step("R9_sext_pos", 1, 3'd2, 3'd1, 3'd5, 8'h11, 8'h7F, 16'h0000, 16'h2222, 16'hFFFF);
        step("R9_sext_narrow", 1, 3'd2, 3'd1, 3'd0, 8'h11, 8'hF0, 16'h0000, 16'h2222, 16'hFFFF);
        step("R10_a2b_zero", 1, 3'd3, 3'd4, 3'd5, 8'h00, 8'h55, 16'h0000, 16'h2222, 16'hFFFF);
        step("R10_b2a_neg", 1, 3'd4, 3'd7, 3'd3, 8'h12, 8'h85, 16'h0000, 16'h2222, 16'hFFFF);
        step("R11_src_none", 1, 3'd0, 3'd6, 3'd3, 8'h12, 8'h85, 16'h7777, 16'h2222, 16'hFFFF);
        step("R11_dst_none", 1, 3'd0, 3'd3, 3'd7, 8'h12, 8'h85, 16'h7777, 16'h2222, 16'hFFFF);

        for (int i = 0; i < 400; i++) begin
            step("R3_R6_R9_R10_random", 1'($urandom_range(0, 7) != 0), 3'($urandom),
                 3'($urandom), 3'($urandom), 8'($urandom), 8'($urandom),
                 16'($urandom), 16'($urandom), 16'($urandom));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule